// File: doc/BRIEF.md
# Byte-Stream Bit-Bang Parallel Port

This block connects a host byte stream to an 8-bit general-purpose I/O port. Bytes arrive over a ready/valid input channel and are driven onto the pins configured as outputs. Samples of the port are returned over a ready/valid output channel. A per-pin direction mask chooses which pins are driven. A programmable rate divider paces every transfer. Active-low write and read strobes mark each port update and each port sample, so external logic can use them as clocks.

Two modes are available. In free-running (asynchronous) mode, a byte is taken on each rate tick. The port is also sampled on every rate tick that finds room in the return slot. In lock-step (synchronous) mode, a sample is taken only when a byte is taken. The sample is captured before the new byte reaches the pins, so the returned data trails the driven data by one byte. A byte is taken only when the return slot can accept its matching sample.

Top module: `bitbang_port`

## Requirements
- R1: While reset is held, `pin_oe` is 0x00, `pin_out` is 0xFF, `wr_strobe_n` and `rd_strobe_n` are high, and `ret_valid` is low. The mode after reset is asynchronous.
- R2: A pulse on `dir_we` loads `dir_val` into the direction mask, which is presented on `pin_oe` (bit n = 1 means pin n is driven). When a byte is taken, only the bits set in the mask take the new byte value. The other bits of `pin_out` keep their previous value.
- R3: A pulse on `mode_we` with `mode_val` = 0x01 selects asynchronous mode. With `mode_val` = 0x04 it selects synchronous mode. Any other value leaves the mode unchanged.
- R4: A byte is taken only on a rate tick. With divider value N, ticks occur exactly every N+1 clocks. A held `cmd_valid` is therefore accepted once every N+1 clocks. The pins show an accepted byte one clock after the accepting edge.
- R5: When no byte is taken, `pin_out` keeps its last value.
- R6: `wr_strobe_n` is low for exactly the one clock after each accepting edge, and is high otherwise.
- R7: `rd_strobe_n` is low for exactly the one clock after each edge at which a sample is pushed into the return slot, and is high otherwise.
- R8: In synchronous mode, each returned byte is the `pin_in` value captured at the edge that takes the matching input byte, which is before that byte is driven. For example, with the pins looped back at 0xFF, sending 0x55, 0xAA, 0xAA returns 0xFF, 0x55, 0xAA.
- R9: In synchronous mode, `cmd_ready` stays low while `ret_valid` is high and `ret_ready` is low.
- R10: In synchronous mode, no sample is produced without an input byte. In asynchronous mode, a sample is produced on every rate tick that finds room.
- R11: While `ret_valid` is high and `ret_ready` is low, `ret_data` holds its value. Asynchronous samples taken in that time are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_we | input | 1 | Mode write pulse |
| mode_val | input | 8 | Mode code (0x01 asynchronous, 0x04 synchronous) |
| dir_we | input | 1 | Direction mask write pulse |
| dir_val | input | 8 | Direction mask, 1 = driven |
| rate_div | input | 16 | Divider value N, tick every N+1 clocks |
| cmd_valid | input | 1 | Input byte valid |
| cmd_ready | output | 1 | Input byte taken this cycle |
| cmd_data | input | 8 | Input byte |
| ret_valid | output | 1 | Returned sample valid |
| ret_ready | input | 1 | Return side can accept |
| ret_data | output | 8 | Returned port sample |
| pin_out | output | 8 | Port output register |
| pin_oe | output | 8 | Per-pin output enable |
| pin_in | input | 8 | Port input sample |
| wr_strobe_n | output | 1 | Active-low port update strobe |
| rd_strobe_n | output | 1 | Active-low port sample strobe |

## Verification
Synchronous mode is exercised with a loopback byte sequence that repeats its last byte. This separates sampling before the byte is driven from sampling after it, because the two orderings return different lists. A partial direction mask with an all-zero byte shows whether undriven bits keep their old value or take the new one. In asynchronous mode, a held input stream shows the N+1 pacing. A stalled return side, with an external input that changes, shows whether the held sample is kept and later samples are dropped. A write of an invalid mode code between two valid ones shows whether unknown codes are ignored.

// File: rtl/bb_pkg.sv
package bb_pkg;
    localparam logic [7:0] MODE_CODE_ASYNC = 8'h01;
    localparam logic [7:0] MODE_CODE_SYNC  = 8'h04;

    typedef enum logic {
        FREE_RUN  = 1'b0,
        LOCK_STEP = 1'b1
    } bb_mode_e;
endpackage

// File: rtl/bb_rate_gen.sv
module bb_rate_gen #(
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] reload,
    output logic          tick
);
    logic [RW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == '0);
        cnt_d = tick ? reload : cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= reload;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bb_ret_slot.sv
module bb_ret_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    output logic         room,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_ready
);
    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        room = !s_q.valid || out_ready;
        s_d  = s_q;
        if (push && room) begin
            s_d.valid = 1'b1;
            s_d.data  = push_data;
        end else if (out_ready) begin
            s_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.valid;
    assign out_data  = s_q.data;
endmodule

// File: rtl/bitbang_port.sv
module bitbang_port
    import bb_pkg::*;
#(
    parameter int PW = 8,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_we,
    input  logic [7:0]    mode_val,
    input  logic          dir_we,
    input  logic [PW-1:0] dir_val,
    input  logic [RW-1:0] rate_div,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [PW-1:0] cmd_data,
    output logic          ret_valid,
    input  logic          ret_ready,
    output logic [PW-1:0] ret_data,
    output logic [PW-1:0] pin_out,
    output logic [PW-1:0] pin_oe,
    input  logic [PW-1:0] pin_in,
    output logic          wr_strobe_n,
    output logic          rd_strobe_n
);
    localparam logic [PW-1:0] PINS_IDLE = {PW{1'b1}};

    typedef struct packed {
        bb_mode_e      mode;
        logic [PW-1:0] dir;
        logic [PW-1:0] pout;
        logic          wr_n;
        logic          rd_n;
    } port_state_t;

    port_state_t st_d, st_q;

    logic tick;
    logic room;
    logic accept;
    logic sample_push;
    logic sync_mode_w;

    bb_rate_gen #(.RW(RW)) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (rate_div),
        .tick   (tick)
    );

    bb_ret_slot #(.W(PW)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (sample_push),
        .push_data (pin_in),
        .room      (room),
        .out_valid (ret_valid),
        .out_data  (ret_data),
        .out_ready (ret_ready)
    );

    always_comb begin
        sync_mode_w = (st_q.mode == LOCK_STEP);
        cmd_ready   = tick && (!sync_mode_w || room);
        accept      = cmd_valid && cmd_ready;
        sample_push = sync_mode_w ? accept : (tick && room);

        st_d = st_q;
        if (mode_we) begin
            if (mode_val == MODE_CODE_ASYNC)     st_d.mode = FREE_RUN;
            else if (mode_val == MODE_CODE_SYNC) st_d.mode = LOCK_STEP;
        end
        if (dir_we) st_d.dir = dir_val;
        if (accept) st_d.pout = (cmd_data & st_q.dir) | (st_q.pout & ~st_q.dir);
        st_d.wr_n = !accept;
        st_d.rd_n = !sample_push;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= FREE_RUN;
            st_q.dir  <= '0;
            st_q.pout <= PINS_IDLE;
            st_q.wr_n <= 1'b1;
            st_q.rd_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_out     = st_q.pout;
    assign pin_oe      = st_q.dir;
    assign wr_strobe_n = st_q.wr_n;
    assign rd_strobe_n = st_q.rd_n;
endmodule

// File: rtl/bitbang_port_chk.sv
module bitbang_port_chk #(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic          ret_valid,
    input logic          ret_ready,
    input logic [PW-1:0] ret_data,
    input logic [PW-1:0] pin_out,
    input logic          wr_strobe_n,
    input logic          rd_strobe_n,
    input logic          sync_mode
);
    assert_wr_follows_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_strobe_n |-> $past(cmd_valid && cmd_ready));

    assert_take_gives_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !wr_strobe_n);

    assert_pins_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_ready) |=> $stable(pin_out));

    assert_sync_needs_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && cmd_ready) |-> (!ret_valid || ret_ready));

    assert_ret_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_ready) |=> (ret_valid && $stable(ret_data)));

    assert_rd_needs_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe_n |-> $past(!ret_valid || ret_ready));
endmodule

bind bitbang_port bitbang_port_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .ret_valid   (ret_valid),
    .ret_ready   (ret_ready),
    .ret_data    (ret_data),
    .pin_out     (pin_out),
    .wr_strobe_n (wr_strobe_n),
    .rd_strobe_n (rd_strobe_n),
    .sync_mode   (sync_mode_w)
);

// File: tb/bitbang_port_bench.sv
module bitbang_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_val = '0;
    logic        dir_we = 1'b0;
    logic [7:0]  dir_val = '0;
    logic [15:0] rate_div = 16'd0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_data = '0;
    logic        ret_valid;
    logic        ret_ready = 1'b1;
    logic [7:0]  ret_data;
    logic [7:0]  pin_out, pin_oe, pin_in;
    logic [7:0]  ext_in = 8'h00;
    logic        wr_strobe_n, rd_strobe_n;

    int errors = 0;
    int checks = 0;
    int rx_n = 0;
    logic [7:0] rx [64];
    bit done = 0;

    always #5 clk = ~clk;

    assign pin_in = (pin_out & pin_oe) | (ext_in & ~pin_oe);

    bitbang_port u_bitbang_port (
        .clk(clk), .rst_n(rst_n),
        .mode_we(mode_we), .mode_val(mode_val),
        .dir_we(dir_we), .dir_val(dir_val),
        .rate_div(rate_div),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in),
        .wr_strobe_n(wr_strobe_n), .rd_strobe_n(rd_strobe_n)
    );

    always @(negedge clk) begin
        if (rst_n && ret_valid && ret_ready && rx_n < 64) begin
            rx[rx_n] = ret_data;
            rx_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_edge();
        @(posedge clk); #2;
    endtask

    task automatic write_mode(input logic [7:0] v);
        drive_edge(); mode_we = 1'b1; mode_val = v;
        drive_edge(); mode_we = 1'b0;
    endtask

    task automatic write_dir(input logic [7:0] v);
        drive_edge(); dir_we = 1'b1; dir_val = v;
        drive_edge(); dir_we = 1'b0;
    endtask

    // Sends one byte and checks strobe and pins (R2, R6)
    task automatic send_byte(input logic [7:0] d, input logic [7:0] exp_pins);
        drive_edge(); cmd_valid = 1'b1; cmd_data = d;
        for (int g = 0; g < 60; g++) begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        drive_edge(); cmd_valid = 1'b0;
        @(negedge clk);
        check(wr_strobe_n == 1'b0, "R6 strobe low after take", wr_strobe_n, 0);
        check(pin_out == exp_pins, "R2 pins after take", pin_out, exp_pins);
        @(negedge clk);
        check(wr_strobe_n == 1'b1, "R6 strobe single clock", wr_strobe_n, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pin_oe == 8'h00, "R1 oe", pin_oe, 0);
        check(pin_out == 8'hFF, "R1 pins", pin_out, 8'hFF);
        check(wr_strobe_n && rd_strobe_n, "R1 strobes", {wr_strobe_n, rd_strobe_n}, 3);
        check(ret_valid == 1'b0, "R1 ret_valid", ret_valid, 0);
        drive_edge(); rst_n = 1'b1;
    endtask

    task automatic t_modes();
        int n;
        write_mode(8'h04);
        repeat (3) @(negedge clk);
        n = rx_n;
        repeat (8) @(negedge clk);
        check(rx_n == n, "R10 sync no free sampling", rx_n - n, 0);
        write_mode(8'h07);
        n = rx_n;
        repeat (8) @(negedge clk);
        check(rx_n == n, "R3 unknown code ignored", rx_n - n, 0);
        write_mode(8'h01);
        n = rx_n;
        repeat (8) @(negedge clk);
        check(rx_n - n >= 6, "R10 async free sampling", rx_n - n, 8);
    endtask

    task automatic t_dir();
        write_mode(8'h04);
        write_dir(8'h0F);
        @(negedge clk);
        check(pin_oe == 8'h0F, "R2 oe mask", pin_oe, 8'h0F);
        send_byte(8'h00, 8'hF0);
    endtask

    task automatic t_lag_example();
        write_dir(8'hFF);
        send_byte(8'hFF, 8'hFF);
        @(negedge clk);
        rx_n = 0;
        send_byte(8'h55, 8'h55);
        send_byte(8'hAA, 8'hAA);
        send_byte(8'hAA, 8'hAA);
        @(negedge clk);
        check(rx_n == 3, "R8 sample count", rx_n, 3);
        check(rx[0] == 8'hFF, "R8 first sample", rx[0], 8'hFF);
        check(rx[1] == 8'h55, "R8 second sample", rx[1], 8'h55);
        check(rx[2] == 8'hAA, "R8 third sample", rx[2], 8'hAA);
    endtask

    task automatic t_backpressure();
        rx_n = 0;
        drive_edge(); ret_ready = 1'b0;
        send_byte(8'h11, 8'h11);
        drive_edge(); cmd_valid = 1'b1; cmd_data = 8'h22;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(cmd_ready == 1'b0, "R9 blocked while full", cmd_ready, 0);
            check(pin_out == 8'h11, "R9 R5 pins held", pin_out, 8'h11);
        end
        drive_edge(); ret_ready = 1'b1;
        @(negedge clk);
        check(cmd_ready == 1'b1, "R9 resumes with room", cmd_ready, 1);
        drive_edge(); cmd_valid = 1'b0;
        @(negedge clk);
        check(pin_out == 8'h22, "R9 byte taken", pin_out, 8'h22);
        @(negedge clk);
        check(rx_n == 2 && rx[0] == 8'hAA && rx[1] == 8'h11, "R8 R9 returned pair",
              {rx[0], rx[1]}, 16'hAA11);
    endtask

    task automatic t_async_pace();
        int ones, rdlo, first, second;
        write_mode(8'h01);
        drive_edge(); rate_div = 16'd3;
        repeat (6) @(negedge clk);
        drive_edge(); cmd_valid = 1'b1; cmd_data = 8'h5A;
        ones = 0; rdlo = 0; first = -1; second = -1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!rd_strobe_n) rdlo++;
            if (cmd_ready) begin
                ones++;
                if (first < 0) first = i;
                else if (second < 0) second = i;
            end
        end
        drive_edge(); cmd_valid = 1'b0;
        check(ones == 3, "R4 takes per 12 clocks", ones, 3);
        check(second - first == 4, "R4 tick spacing", second - first, 4);
        check(rdlo == 3, "R7 rd strobe per tick", rdlo, 3);
        @(negedge clk);
        check(pin_out == 8'h5A, "R4 async byte driven", pin_out, 8'h5A);
        repeat (10) @(negedge clk);
        check(pin_out == 8'h5A, "R5 hold without bytes", pin_out, 8'h5A);
        check(wr_strobe_n == 1'b1, "R6 idle strobe high", wr_strobe_n, 1);
    endtask

    task automatic t_async_drop();
        write_dir(8'h00);
        drive_edge(); ext_in = 8'h3C;
        repeat (10) @(negedge clk);
        drive_edge(); ret_ready = 1'b0;
        repeat (6) @(negedge clk);
        check(ret_valid && ret_data == 8'h3C, "R11 held sample", ret_data, 8'h3C);
        drive_edge(); ext_in = 8'hC3;
        repeat (12) @(negedge clk);
        check(ret_valid && ret_data == 8'h3C, "R11 later samples dropped", ret_data, 8'h3C);
        rx_n = 0;
        drive_edge(); ret_ready = 1'b1;
        repeat (12) @(negedge clk);
        check(rx_n >= 2 && rx[0] == 8'h3C && rx[rx_n-1] == 8'hC3, "R11 resume after stall",
              rx[rx_n-1], 8'hC3);
    endtask

    initial begin
        t_reset();
        t_modes();
        t_dir();
        t_lag_example();
        t_backpressure();
        t_async_pace();
        t_async_drop();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule